// File: doc/BRIEF.md
# Four-Way Write-Back Data Cache with Way Lockdown

This block is a 4 KB data cache that sits between a processor's single-word load/store port and a word-wide memory port. It has four ways of 1 KB each. Every way holds 32 lines, and each line is eight 32-bit words. A read or write that hits is served from the cache and does not touch memory. On a miss, the block picks a victim way. If that line is dirty, the block writes it back to memory as an 8-beat burst. It then fills the new line with an 8-beat burst, and the original access is replayed against that line. Writes that hit only mark the line dirty, so memory is updated when the line is evicted.

Any whole way can be pinned through a lock mask. A pinned way keeps answering hits, including write hits, but it is never chosen as a victim. Victims rotate round-robin over the ways that are not pinned. When every way is pinned, a miss becomes one uncached word transfer and nothing is allocated.

Caching is active only while the enable bit of the control word is set and the protection-enable input is high. Otherwise every access passes straight through as a single-word transfer. The block leaves reset with caching off and all four ways pinned.

Top module: `lockway_dcache`

## Requirements
- R1: Reset (synchronous, rst_n low) leaves the block idle with req_ready high, mem_req and resp_valid low, caching off, and lock mask 4'b1111, so that once caching is switched on the first miss is still a single uncached beat.
- R2: While caching is inactive, each access makes exactly one memory transfer at the request address with mem_burst low, and nothing is allocated: repeating the same access again reaches memory.
- R3: Caching is active only when bit 2 of the last word written through cfg_we is 1 and prot_en is 1. Every other control bit is ignored.
- R4: Addresses split into a word select in bits 4:2, a set index in bits 9:5 and a tag in bits 31:10. A line fill is 8 beats with mem_burst high, at the line base plus 4*i for i = 0 to 7 in ascending order.
- R5: A read hit returns the stored word, and a write hit updates the line. Neither makes any memory transfer, and a write hit leaves memory unchanged.
- R6: A miss that finds an unlocked way fills the whole line, starting at word 0, and then completes the access. The data of a write miss is merged into the line, and a read of it afterwards hits.
- R7: When the victim line is dirty, its 8 words are written to memory in ascending address order, with mem_write high, before the fill begins.
- R8: Bit w of the lock mask (written with lock_we) pins way w. A pinned way still hits but is never chosen as a victim.
- R9: With all four ways pinned, a miss becomes one uncached word transfer with no allocation.
- R10: Victims rotate round-robin over the unpinned ways. With no way pinned, four misses to four different tags of one set leave all four lines resident.
- R11: Every read returns the value most recently written to that address, across any mix of hits, misses, evictions and lock changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word; bit 2 enables caching |
| lock_we | input | 1 | Write strobe for the lock mask |
| lock_wdata | input | 4 | Lock mask, one bit per way |
| prot_en | input | 1 | Protection enable; caching is allowed only while high |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Word-aligned byte address |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | One-cycle pulse when the access completes |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| mem_req | output | 1 | Memory beat request |
| mem_write | output | 1 | Memory beat is a write |
| mem_burst | output | 1 | Beat belongs to an 8-beat line burst |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the current beat |
| mem_rdata | input | 32 | Memory read data for the acknowledged beat |

## Verification
Directed sequences separate the three ways an access can be routed: a pass-through word (inactive caching, gated either by the control bit or by protection, or all ways pinned), a clean fill, and a dirty write-back followed by a fill. The bench tells these apart by counting memory beats and reading the beat log's addresses and directions. A set is filled across all four ways and then three ways are pinned. The count of lines that survive repeated evictions then distinguishes correct lockdown from lockdown that is ignored. A random phase mixes reads, writes and lock masks over sixteen tags in four sets to exercise conflict misses. Each read is compared with a bench-held shadow of the processor's view of memory.

// File: rtl/lwc_pkg.sv
// Shared types for the lockway data cache.
package lwc_pkg;
    // Controller states: idle, tag lookup, dirty write-back, line fill,
    // uncached single word, response.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WBACK,
        ST_FILL,
        ST_DIRECT,
        ST_RESP
    } lwc_state_e;
endpackage

// File: rtl/lwc_victim.sv
// Round-robin victim picker.
// Starting from a rotating pointer, picks the first way whose lock bit is clear.
// Flags none_free when all ways are locked.
// Assumes WAYS is a power of two and at least 2.
module lwc_victim #(
    parameter int WAYS = 4,
    localparam int IW = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [WAYS-1:0] lock_mask,
    input  logic            adv,
    input  logic [IW-1:0]   used_way,
    output logic [IW-1:0]   pick,
    output logic            none_free
);
    logic [IW-1:0] ptr;
    logic [IW-1:0] cand;

    // Search from the pointer; the lowest offset that is unlocked wins.
    always_comb begin
        pick      = ptr;
        none_free = 1'b1;
        cand      = ptr;
        for (int i = WAYS - 1; i >= 0; i--) begin
            cand = ptr + IW'(i);
            if (!lock_mask[cand]) begin
                pick      = cand;
                none_free = 1'b0;
            end
        end
    end

    // Move the pointer past the way that was just allocated.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv)
            ptr <= used_way + 1'b1;
    end

    a_r8_pick_is_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !none_free |-> !lock_mask[pick]);
    a_r9_none_when_all_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (&lock_mask) |-> none_free);
endmodule

// File: rtl/lwc_tags.sv
// Tag, valid and dirty store, with parallel hit detection for every way.
// Lookup, allocation and dirty marking all use the set of the current request.
// Also reports the tag, valid and dirty state of one selected way (info_way) for victim handling.
module lwc_tags #(
    parameter int WAYS  = 4,
    parameter int SETS  = 32,
    parameter int TAG_W = 22,
    localparam int IW = $clog2(WAYS),
    localparam int SW = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    look_set,
    input  logic [TAG_W-1:0] look_tag,
    output logic [WAYS-1:0]  hit_vec,
    output logic [IW-1:0]    hit_way,
    input  logic [IW-1:0]    info_way,
    output logic [TAG_W-1:0] info_tag,
    output logic             info_valid,
    output logic             info_dirty,
    input  logic             alloc_en,
    input  logic [IW-1:0]    alloc_way,
    input  logic             dirty_en,
    input  logic [IW-1:0]    dirty_way
);
    logic [TAG_W-1:0] way_tag [WAYS];
    logic [WAYS-1:0]  way_val;
    logic [WAYS-1:0]  way_dty;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [SETS-1:0]  val_q;
        logic [SETS-1:0]  dty_q;

        // Valid and dirty bits: cleared by reset, set by allocation or by a write hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                dty_q <= '0;
            end else if (alloc_en && alloc_way == IW'(w)) begin
                val_q[look_set] <= 1'b1;
                dty_q[look_set] <= 1'b0;
            end else if (dirty_en && dirty_way == IW'(w)) begin
                dty_q[look_set] <= 1'b1;
            end
        end

        // Tag storage: written when a line is allocated.
        always_ff @(posedge clk) begin
            if (alloc_en && alloc_way == IW'(w))
                tag_q[look_set] <= look_tag;
        end

        assign way_tag[w] = tag_q[look_set];
        assign way_val[w] = val_q[look_set];
        assign way_dty[w] = dty_q[look_set];
        assign hit_vec[w] = val_q[look_set] && (tag_q[look_set] == look_tag);
    end

    // Encode the hitting way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = IW'(w);
    end

    assign info_tag   = way_tag[info_way];
    assign info_valid = way_val[info_way];
    assign info_dirty = way_dty[info_way];

    a_r5_single_way_hits: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/lwc_data.sv
// Line data storage, one word per entry, addressed by {way, set, word}.
// One combinational read port and one synchronous write port.
// Contents are not reset; valid bits in the tag store guard them.
module lwc_data #(
    parameter int WAYS   = 4,
    parameter int SETS   = 32,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IW = $clog2(WAYS),
    localparam int SW = $clog2(SETS),
    localparam int WW = $clog2(WORDS),
    localparam int DEPTH = WAYS * SETS * WORDS
) (
    input  logic              clk,
    input  logic [IW-1:0]     way,
    input  logic [SW-1:0]     set,
    input  logic [WW-1:0]     word,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    // Single write port used by write hits and fill beats.
    always_ff @(posedge clk) begin
        if (we)
            mem_q[{way, set, word}] <= wdata;
    end

    assign rdata = mem_q[{way, set, word}];
endmodule

// File: rtl/lockway_dcache.sv
// Top of the four-way write-back data cache with way lockdown.
// Accepts one request at a time from the processor port and runs the controller FSM:
// lookup, optional dirty write-back, line fill, replay, or uncached pass-through.
// Assumes power-of-two geometry, word-aligned requests and a memory that keeps
// mem_addr and mem_wdata for each beat until mem_ack.
module lockway_dcache
    import lwc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAYS   = 4,
    parameter int SETS   = 32,
    parameter int WORDS  = 8,
    parameter int EN_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              lock_we,
    input  logic [WAYS-1:0]   lock_wdata,
    input  logic              prot_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic              mem_burst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int IW    = $clog2(WAYS);
    localparam int SW    = $clog2(SETS);
    localparam int WW    = $clog2(WORDS);
    localparam int BW    = $clog2(DATA_W / 8);
    localparam int OFF_W = WW + BW;
    localparam int TAG_W = ADDR_W - SW - OFF_W;
    localparam logic [WW-1:0] LAST = WW'(WORDS - 1);

    lwc_state_e        st;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              w_q;
    logic [WW-1:0]     beat;
    logic [IW-1:0]     vway;
    logic              en_q;
    logic [WAYS-1:0]   lock_q;

    logic [SW-1:0]     set_i;
    logic [TAG_W-1:0]  tag_i;
    logic [WW-1:0]     word_i;
    logic              active;
    logic [WAYS-1:0]   hit_vec;
    logic              hit;
    logic [IW-1:0]     hit_way;
    logic [IW-1:0]     pick;
    logic              none_free;
    logic [IW-1:0]     info_way;
    logic [TAG_W-1:0]  vic_tag;
    logic              vic_valid;
    logic              vic_dirty;
    logic              alloc_en;
    logic              wr_hit;
    logic [IW-1:0]     dat_way;
    logic [WW-1:0]     dat_word;
    logic              dat_we;
    logic [DATA_W-1:0] dat_wdata;
    logic [DATA_W-1:0] dat_rd;

    assign set_i    = a_q[OFF_W +: SW];
    assign tag_i    = a_q[ADDR_W-1 -: TAG_W];
    assign word_i   = a_q[BW +: WW];
    assign active   = en_q && prot_en;
    assign hit      = |hit_vec;
    assign wr_hit   = (st == ST_LOOK) && active && hit && w_q;
    assign alloc_en = (st == ST_FILL) && mem_ack && (beat == LAST);
    assign info_way = (st == ST_LOOK) ? pick : vway;

    // Data array port steering: lookup uses the hit way, bursts use the victim.
    assign dat_way   = (st == ST_LOOK) ? hit_way : vway;
    assign dat_word  = (st == ST_LOOK) ? word_i : beat;
    assign dat_we    = wr_hit || ((st == ST_FILL) && mem_ack);
    assign dat_wdata = (st == ST_FILL) ? mem_rdata : d_q;

    lwc_victim #(.WAYS(WAYS)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_mask (lock_q),
        .adv       (alloc_en),
        .used_way  (vway),
        .pick      (pick),
        .none_free (none_free)
    );

    lwc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_set   (set_i),
        .look_tag   (tag_i),
        .hit_vec    (hit_vec),
        .hit_way    (hit_way),
        .info_way   (info_way),
        .info_tag   (vic_tag),
        .info_valid (vic_valid),
        .info_dirty (vic_dirty),
        .alloc_en   (alloc_en),
        .alloc_way  (vway),
        .dirty_en   (wr_hit),
        .dirty_way  (hit_way)
    );

    lwc_data #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .way   (dat_way),
        .set   (set_i),
        .word  (dat_word),
        .we    (dat_we),
        .wdata (dat_wdata),
        .rdata (dat_rd)
    );

    // Control bit and lock mask: reset to disabled and fully locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            lock_q <= '1;
        end else begin
            if (cfg_we)  en_q   <= cfg_wdata[EN_BIT];
            if (lock_we) lock_q <= lock_wdata;
        end
    end

    // Controller FSM: sequences lookup, write-back, fill and pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            a_q        <= '0;
            d_q        <= '0;
            w_q        <= 1'b0;
            beat       <= '0;
            vway       <= '0;
            resp_rdata <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (req_valid) begin
                    a_q <= req_addr;
                    d_q <= req_wdata;
                    w_q <= req_write;
                    st  <= ST_LOOK;
                end
                ST_LOOK: begin
                    beat <= '0;
                    if (!active || (!hit && none_free)) begin
                        st <= ST_DIRECT;
                    end else if (hit) begin
                        if (!w_q) resp_rdata <= dat_rd;
                        st <= ST_RESP;
                    end else begin
                        vway <= pick;
                        st   <= (vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST) st <= ST_FILL;
                end
                ST_FILL: if (mem_ack) begin
                    beat <= beat + 1'b1;
                    if (beat == LAST) st <= ST_LOOK;
                end
                ST_DIRECT: if (mem_ack) begin
                    if (!w_q) resp_rdata <= mem_rdata;
                    st <= ST_RESP;
                end
                ST_RESP: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Memory port: line bursts use the line base plus the beat index.
    always_comb begin
        mem_req   = (st == ST_WBACK) || (st == ST_FILL) || (st == ST_DIRECT);
        mem_write = (st == ST_WBACK) || ((st == ST_DIRECT) && w_q);
        mem_burst = (st == ST_WBACK) || (st == ST_FILL);
        mem_wdata = (st == ST_WBACK) ? dat_rd : d_q;
        unique case (st)
            ST_WBACK: mem_addr = {vic_tag, set_i, beat, BW'(0)};
            ST_FILL:  mem_addr = {tag_i, set_i, beat, BW'(0)};
            default:  mem_addr = a_q;
        endcase
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = (st == ST_RESP);

    a_r2_no_burst_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !(en_q && prot_en)) |-> !mem_burst);
    a_r4_burst_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_burst && mem_addr[BW +: WW] != LAST)
        |=> (mem_burst && mem_addr[BW +: WW] == WW'($past(mem_addr[BW +: WW]) + 1'b1)));
    a_r7_wback_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_burst && mem_write && mem_addr[BW +: WW] == LAST)
        |=> (mem_req && mem_burst && !mem_write && mem_addr[BW +: WW] == '0));
    a_r8_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WBACK || st == ST_FILL) |-> !lock_q[vway]);
    a_r9_all_locked_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK && active && !hit && (&lock_q)) |=> (st == ST_DIRECT));
    a_r5_resp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));
endmodule

// File: tb/lockway_dcache_bench.sv
// Self-checking bench: directed corner cases followed by seeded random traffic.
module lockway_dcache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        lock_we = 1'b0;
    logic [3:0]  lock_wdata = '0;
    logic        prot_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_req, mem_write, mem_burst, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;   // 4 ns period

    lockway_dcache u_lockway_dcache (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .lock_we(lock_we), .lock_wdata(lock_wdata), .prot_en(prot_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
        .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_write(mem_write),
        .mem_burst(mem_burst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [31:0] bmem [0:4095];
    logic [31:0] gold [0:4095];
    int          tot_beats;
    logic [31:0] lg_addr [0:63];
    logic        lg_we [0:63];
    logic        lg_burst [0:63];
    int          n_chk = 0;
    int          n_err = 0;
    int          a_beats;
    int          a_start;
    logic [31:0] a_rd;
    bit          done = 0;

    function automatic logic [31:0] seed_word(int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] line_beat(logic [31:0] a, int i);
        return {a[31:5], 5'd0} + 32'(4 * i);
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = bmem[mem_addr[13:2]];

    // Memory model and beat log.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) bmem[i] <= seed_word(i);
            tot_beats <= 0;
        end else if (mem_req && mem_ack) begin
            lg_addr[tot_beats[5:0]]  <= mem_addr;
            lg_we[tot_beats[5:0]]    <= mem_write;
            lg_burst[tot_beats[5:0]] <= mem_burst;
            if (mem_write) bmem[mem_addr[13:2]] <= mem_wdata;
            tot_beats <= tot_beats + 1;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd);
        @(negedge clk);
        a_start   = tot_beats;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (resp_valid !== 1'b1) @(negedge clk);
        a_rd    = resp_rdata;
        a_beats = tot_beats - a_start;
        if (wr) gold[addr[13:2]] = wd;
    endtask

    task automatic rd_chk(string req, logic [31:0] addr);
        access(1'b0, addr, '0);
        chk(req, "read data", a_rd, gold[addr[13:2]]);
    endtask

    task automatic set_cfg(logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic set_lock(logic [3:0] v);
        @(negedge clk); lock_we = 1'b1; lock_wdata = v;
        @(negedge clk); lock_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int hits;
        logic [31:0] a;
        for (int i = 0; i < 4096; i++) gold[i] = seed_word(i);
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd0);

        // R2: caching off, single pass-through beats, no allocation
        rd_chk("R2", 32'h100);
        chk("R2", "beats", 32'(a_beats), 32'd1);
        chk("R2", "burst", 32'(lg_burst[a_start[5:0]]), 32'd0);
        chk("R2", "addr", lg_addr[a_start[5:0]], 32'h100);
        access(1'b1, 32'h104, 32'hCAFE0104);
        chk("R2", "write beats", 32'(a_beats), 32'd1);
        chk("R2", "write mem", bmem[32'h104 >> 2], 32'hCAFE0104);
        rd_chk("R2", 32'h100);
        chk("R2", "repeat beats", 32'(a_beats), 32'd1);

        // R1 / R9: enabled but locked from reset -> uncached, no allocation
        prot_en = 1'b1;
        set_cfg(32'h4);
        rd_chk("R9", 32'h200);
        chk("R1", "locked after reset beats", 32'(a_beats), 32'd1);
        rd_chk("R9", 32'h200);
        chk("R9", "no allocation beats", 32'(a_beats), 32'd1);

        // R3: gating by protection and by bit 2 only
        set_lock(4'b0000);
        prot_en = 1'b0;
        rd_chk("R3", 32'h300);
        chk("R3", "prot off beats", 32'(a_beats), 32'd1);
        prot_en = 1'b1;
        set_cfg(32'hFFFF_FFFB);
        rd_chk("R3", 32'h340);
        chk("R3", "bit2 clear beats", 32'(a_beats), 32'd1);
        set_cfg(32'h0000_0004);
        rd_chk("R3", 32'h340);
        chk("R3", "enabled fill beats", 32'(a_beats), 32'd8);

        // R4 / R6: line fill order from word 0
        rd_chk("R6", 32'h1014);
        chk("R6", "fill beats", 32'(a_beats), 32'd8);
        for (int i = 0; i < 8; i++) begin
            chk("R4", "fill addr", lg_addr[6'(a_start + i)], line_beat(32'h1014, i));
            chk("R4", "fill burst", 32'(lg_burst[6'(a_start + i)]), 32'd1);
        end

        // R5: read and write hits stay off the memory port
        rd_chk("R5", 32'h1008);
        chk("R5", "read hit beats", 32'(a_beats), 32'd0);
        access(1'b1, 32'h1008, 32'h1234_5678);
        chk("R5", "write hit beats", 32'(a_beats), 32'd0);
        chk("R5", "memory untouched", bmem[32'h1008 >> 2], seed_word(32'h1008 >> 2));
        rd_chk("R5", 32'h1008);
        chk("R5", "reread beats", 32'(a_beats), 32'd0);

        // R10: four tags in set 3 all stay resident
        for (int k = 8; k < 12; k++) rd_chk("R10", 32'(k * 32'h400 + 32'h60));
        for (int k = 8; k < 12; k++) begin
            rd_chk("R10", 32'(k * 32'h400 + 32'h60));
            chk("R10", "resident beats", 32'(a_beats), 32'd0);
        end

        // R6 / R7: one free way; write miss merges, dirty eviction writes back first
        set_lock(4'b1110);
        access(1'b1, 32'h3064, 32'hDEAD_3064);
        chk("R6", "write miss beats", 32'(a_beats), 32'd8);
        rd_chk("R6", 32'h3064);
        chk("R6", "merged hit beats", 32'(a_beats), 32'd0);
        rd_chk("R7", 32'h3460);
        chk("R7", "evict beats", 32'(a_beats), 32'd16);
        for (int i = 0; i < 8; i++) begin
            chk("R7", "wb dir", 32'(lg_we[6'(a_start + i)]), 32'd1);
            chk("R7", "wb addr", lg_addr[6'(a_start + i)], line_beat(32'h3060, i));
            chk("R7", "fill dir", 32'(lg_we[6'(a_start + 8 + i)]), 32'd0);
            chk("R7", "fill addr", lg_addr[6'(a_start + 8 + i)], line_beat(32'h3460, i));
            chk("R7", "wb data", bmem[(32'h3060 >> 2) + i], gold[(32'h3060 >> 2) + i]);
        end

        // R8: three pinned ways keep their lines
        hits = 0;
        for (int k = 8; k < 12; k++) begin
            rd_chk("R8", 32'(k * 32'h400 + 32'h60));
            if (a_beats == 0) hits++;
        end
        chk("R8", "surviving lines", 32'(hits), 32'd3);

        // R11: random traffic with changing lock masks
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0) set_lock(4'($urandom_range(0, 15)));
            a = 32'(($urandom_range(0, 15) << 10) | ($urandom_range(0, 3) << 5)
                    | ($urandom_range(0, 7) << 2));
            if ($urandom_range(0, 2) == 0) access(1'b1, a, $urandom());
            else rd_chk("R11", a);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule